// File: doc/BRIEF.md
# Quad Two-Source Multiplexing Latch

The block holds four identical one-bit slices. Every slice forms a value from its two data inputs according to a 2-bit select code shared by all slices. The code can pass the first source, pass the second source, OR both sources together, or force a LOW. That value then goes through a storage stage that is transparent only while both active-low enables are LOW. Once either enable goes HIGH, the stage holds the value it saw last while it was open.

An active-high master reset overrides everything else. It drives all true outputs LOW at once and clears the stored bits. Every slice also drives a complementary output. Storage is modelled as a sampled equivalent of a level latch. The held bit updates on each clock edge while the stage is open, and the outputs pass through combinationally while the stage is open.

Top module: `mlq_quad`

## Requirements
- R1: With both enables LOW and select code 2'b00, each `q[i]` equals `din_a[i]` in the same cycle.
- R2: With both enables LOW and select code 2'b11, each `q[i]` equals `din_b[i]`.
- R3: With both enables LOW and select code 2'b10, each `q[i]` equals `din_a[i] | din_b[i]`.
- R4: With both enables LOW and select code 2'b01, every `q` bit is LOW whatever the data inputs are.
- R5: The stage is open only when both `en1_n` and `en2_n` are LOW. A HIGH on either one alone closes it.
- R6: When the stage closes, `q` keeps the value it showed at the last clock edge at which the stage was open.
- R7: While `mrst` is HIGH, every `q` bit is LOW in the same cycle, whatever the enables, select code or data are.
- R8: If `mrst` falls while the stage is closed, `q` stays LOW until both enables are LOW again.
- R9: `q_n` is always the bitwise inverse of `q`, including during reset and hold.
- R10: A clock edge with `rst_n` LOW clears the held bits. After reset, with the stage closed, `q` reads 0.
- R11: Changes on select or data inputs while the stage is closed do not alter `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the held bits |
| rst_n | input | 1 | Synchronous active-low reset of the held bits |
| mrst | input | 1 | Active-high master reset, forces `q` LOW |
| en1_n | input | 1 | First active-low enable |
| en2_n | input | 1 | Second active-low enable |
| sel | input | 2 | Shared select code: 00 first source, 01 LOW, 10 OR, 11 second source |
| din_a | input | W | First data source, one bit per slice |
| din_b | input | W | Second data source, one bit per slice |
| q | output | W | True outputs |
| q_n | output | W | Complementary outputs |

## Verification
Master reset and a capture can land in the same cycle. This happens when one enable rises in the very step that raises `mrst`. Reset must win, so the held bits must not keep the data that was passing just before. The bench opens the stage on all-ones data and then raises `en1_n` and `mrst` together. It then drops `mrst` while the stage is still closed. It expects `q` to read 0 in both steps, and to show fresh data only after both enables go LOW.

// File: rtl/mlq_pkg.sv
// Shared types for the quad multiplexing latch.
// Assumes the select encoding is fixed by the slice behaviour listed below.
package mlq_pkg;

    // Select code shared by all slices
    typedef enum logic [1:0] {
        SRC_A    = 2'b00,  // pass first source
        SRC_ZERO = 2'b01,  // force LOW
        SRC_OR   = 2'b10,  // OR of both sources
        SRC_B    = 2'b11   // pass second source
    } src_sel_e;

endpackage

// File: rtl/mlq_ctrl.sv
// Control decode: combines the two active-low enables into one open flag
// and folds the synchronous reset and master reset into one clear request.
// Assumes all inputs are already synchronous to clk where it matters.
module mlq_ctrl (
    input  logic en1_n,
    input  logic en2_n,
    input  logic rst_n,
    input  logic mrst,
    output logic open,
    output logic clear
);

    // Stage opens only when both enables are low
    always_comb begin
        open  = ~en1_n & ~en2_n;
        clear = ~rst_n | mrst;
    end

endmodule

// File: rtl/mlq_mux.sv
// One-bit source combiner for a slice.
// Assumes the select code uses the encoding of mlq_pkg::src_sel_e.
module mlq_mux
    import mlq_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       da,
    input  logic       db,
    output logic       y
);

    src_sel_e mode;

    // Choose or combine the two sources per the select code
    always_comb begin
        mode = src_sel_e'(sel);
        case (mode)
            SRC_A:    y = da;
            SRC_ZERO: y = 1'b0;
            SRC_OR:   y = da | db;
            SRC_B:    y = db;
            default:  y = 1'b0;
        endcase
    end

endmodule

// File: rtl/mlq_hold.sv
// Sampled storage bit standing in for a level latch: loads while open,
// clears on request, otherwise keeps its value.
// Assumes clear has priority over load.
module mlq_hold (
    input  logic clk,
    input  logic clear,
    input  logic load,
    input  logic d,
    output logic held
);

    // Update the held bit once per clock
    always_ff @(posedge clk) begin
        if (clear)
            held <= 1'b0;
        else if (load)
            held <= d;
    end

endmodule

// File: rtl/mlq_quad.sv
// Quad two-source multiplexing latch. W slices share the select code,
// both enables and both resets. Each slice passes its combined value
// straight through while open and shows its held bit while closed.
// Master reset overrides the output combinationally.
// Assumes inputs change away from the active clock edge.
module mlq_quad #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mrst,
    input  logic         en1_n,
    input  logic         en2_n,
    input  logic [1:0]   sel,
    input  logic [W-1:0] din_a,
    input  logic [W-1:0] din_b,
    output logic [W-1:0] q,
    output logic [W-1:0] q_n
);

    logic open;
    logic clear;

    mlq_ctrl u_ctrl (
        .en1_n (en1_n),
        .en2_n (en2_n),
        .rst_n (rst_n),
        .mrst  (mrst),
        .open  (open),
        .clear (clear)
    );

    for (genvar i = 0; i < W; i++) begin : g_slice
        logic mux_y;
        logic held;

        mlq_mux u_mux (
            .sel (sel),
            .da  (din_a[i]),
            .db  (din_b[i]),
            .y   (mux_y)
        );

        mlq_hold u_hold (
            .clk   (clk),
            .clear (clear),
            .load  (open),
            .d     (mux_y),
            .held  (held)
        );

        // Drive the slice outputs: reset, then pass-through, then held bit
        always_comb begin
            if (mrst)
                q[i] = 1'b0;
            else if (open)
                q[i] = mux_y;
            else
                q[i] = held;
            q_n[i] = ~q[i];
        end
    end

endmodule

// File: rtl/mlq_quad_chk.sv
// Property checker for mlq_quad, attached by bind.
module mlq_quad_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mrst,
    input logic         en1_n,
    input logic         en2_n,
    input logic [1:0]   sel,
    input logic [W-1:0] din_a,
    input logic [W-1:0] din_b,
    input logic [W-1:0] q,
    input logic [W-1:0] q_n
);

    logic closed;
    assign closed = en1_n | en2_n;

    // R1
    pass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!closed && !mrst && sel == 2'b00) |-> (q == din_a));

    // R4
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!closed && sel == 2'b01) |-> (q == '0));

    // R7
    mrst_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |-> (q == '0));

    // R8
    release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mrst) && closed) |-> (q == '0));

    // R6
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (closed && !mrst && !$past(en1_n | en2_n) && !$past(mrst) && $past(rst_n))
        |-> (q == $past(q)));

    // R9
    inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q ^ q_n) == {W{1'b1}});

endmodule

bind mlq_quad mlq_quad_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .mrst  (mrst),
    .en1_n (en1_n),
    .en2_n (en2_n),
    .sel   (sel),
    .din_a (din_a),
    .din_b (din_b),
    .q     (q),
    .q_n   (q_n)
);

// File: tb/sim_mlq_quad.sv
module sim_mlq_quad;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mrst = 1'b0;
    logic         en1_n = 1'b1;
    logic         en2_n = 1'b1;
    logic [1:0]   sel = 2'b00;
    logic [W-1:0] din_a = '0;
    logic [W-1:0] din_b = '0;
    logic [W-1:0] q;
    logic [W-1:0] q_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0] exp_q[$];
    bit           exp_c[$];
    string        exp_t[$];
    logic [W-1:0] ref_held = '0;

    always #5 clk = ~clk;

    mlq_quad #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .mrst(mrst), .en1_n(en1_n), .en2_n(en2_n),
        .sel(sel), .din_a(din_a), .din_b(din_b), .q(q), .q_n(q_n)
    );

    function automatic logic [W-1:0] ref_mux(input logic [1:0] s,
                                             input logic [W-1:0] a, b);
        case (s)
            2'b00:   return a;
            2'b01:   return '0;
            2'b10:   return a | b;
            default: return b;
        endcase
    endfunction

    task automatic step(input logic r_n, m, e1, e2, input logic [1:0] s,
                        input logic [W-1:0] a, b, input string tag, input bit chk);
        logic         op;
        logic [W-1:0] mx;
        logic [W-1:0] e;
        @(negedge clk);
        rst_n = r_n; mrst = m; en1_n = e1; en2_n = e2; sel = s; din_a = a; din_b = b;
        op = !e1 && !e2;
        mx = ref_mux(s, a, b);
        e  = m ? '0 : (op ? mx : ref_held);
        exp_q.push_back(e); exp_c.push_back(chk); exp_t.push_back(tag);
        if (!r_n || m) ref_held = '0;
        else if (op)   ref_held = mx;
    endtask

    // Monitor: pop expected items and compare after inputs settle
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (exp_q.size() > 0) begin
                logic [W-1:0] e;
                bit c;
                string t;
                e = exp_q.pop_front(); c = exp_c.pop_front(); t = exp_t.pop_front();
                if (c) begin
                    checks++;
                    if (q !== e) begin
                        errors++;
                        $display("FAIL %s q=%h expected %h", t, q, e);
                    end
                    checks++;
                    if (q_n !== ~e) begin
                        errors++;
                        $display("FAIL R9 q_n=%h expected %h", q_n, ~e);
                    end
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset with stage closed
        step(0, 0, 1, 1, 2'b00, 4'h0, 4'h0, "R10", 0);
        step(0, 0, 1, 1, 2'b00, 4'h0, 4'h0, "R10", 1);
        step(1, 0, 1, 1, 2'b00, 4'hF, 4'hF, "R10", 1);
        // R1: pass first source
        step(1, 0, 0, 0, 2'b00, 4'h5, 4'hA, "R1", 1);
        step(1, 0, 0, 0, 2'b00, 4'hC, 4'h3, "R1", 1);
        // R2: pass second source
        step(1, 0, 0, 0, 2'b11, 4'h5, 4'hA, "R2", 1);
        step(1, 0, 0, 0, 2'b11, 4'hF, 4'h6, "R2", 1);
        // R3: OR of both
        step(1, 0, 0, 0, 2'b10, 4'h3, 4'h8, "R3", 1);
        step(1, 0, 0, 0, 2'b10, 4'h0, 4'h0, "R3", 1);
        step(1, 0, 0, 0, 2'b10, 4'h5, 4'hA, "R3", 1);
        // R4: force low
        step(1, 0, 0, 0, 2'b01, 4'hF, 4'hF, "R4", 1);
        // R6: capture on en1_n rise
        step(1, 0, 0, 0, 2'b00, 4'h9, 4'h0, "R1", 1);
        step(1, 0, 1, 0, 2'b00, 4'h6, 4'h0, "R6", 1);
        // R11: inputs change while closed
        step(1, 0, 1, 0, 2'b11, 4'h0, 4'hF, "R11", 1);
        step(1, 0, 1, 0, 2'b10, 4'hF, 4'hF, "R11", 1);
        // R5: only en2_n high also closes
        step(1, 0, 0, 0, 2'b11, 4'h0, 4'h3, "R2", 1);
        step(1, 0, 0, 1, 2'b11, 4'h0, 4'hC, "R5", 1);
        step(1, 0, 0, 1, 2'b00, 4'hF, 4'hC, "R5", 1);
        step(1, 0, 0, 0, 2'b00, 4'hE, 4'h0, "R5", 1);
        // R7: master reset while open and while closed
        step(1, 1, 0, 0, 2'b00, 4'hF, 4'hF, "R7", 1);
        step(1, 1, 1, 1, 2'b11, 4'hF, 4'hF, "R7", 1);
        // R8: release while closed keeps low
        step(1, 0, 1, 1, 2'b11, 4'hF, 4'hF, "R8", 1);
        step(1, 0, 1, 0, 2'b10, 4'hF, 4'hF, "R8", 1);
        step(1, 0, 0, 0, 2'b11, 4'h0, 4'h7, "R8", 1);
        // Reset and capture in the same cycle
        step(1, 0, 0, 0, 2'b00, 4'hF, 4'h0, "R1", 1);
        step(1, 1, 1, 0, 2'b00, 4'hF, 4'h0, "R7", 1);
        step(1, 0, 1, 0, 2'b00, 4'hF, 4'h0, "R8", 1);
        step(1, 0, 0, 0, 2'b00, 4'hB, 4'h0, "R1", 1);
        // R10: synchronous reset clears held value
        step(1, 0, 1, 1, 2'b00, 4'h0, 4'h0, "R6", 1);
        step(0, 0, 1, 1, 2'b00, 4'h0, 4'h0, "R10", 0);
        step(1, 0, 1, 1, 2'b00, 4'h0, 4'h0, "R10", 1);
        @(negedge clk);
        #5;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule